// File: doc/BRIEF.md
# Earliest-hit channel address encoder

This block watches a bank of per-channel discriminator hit lines and, once per bunch-crossing period, reports which channel fired first. Hits are single-cycle pulses sampled on a clock that runs several times faster than the crossing rate. The first unmasked pulse of a crossing is latched. Any later pulse in the same crossing leaves that latched address alone. When the crossing strobe arrives, the latched address, or failing that the winner of the strobe cycle itself, is moved to the registered outputs. The latch is then emptied for the next crossing.

The result is a fast trigger primitive: a channel address that is valid together with an any-hit flag, which acts as a fast OR across the unmasked channels. A per-channel mask removes noisy channels from both the address and the OR. When several channels rise in the same sampling cycle, the lowest index is reported. The reset is asserted asynchronously and released on the clock through a two-stage synchronizer.

Top module: `earliest_hit_addr`

## Requirements
- R1: While reset is applied, and until the first crossing strobe after release, `hit_addr` is 0, `addr_valid` is 0 and `any_hit` is 0.
- R2: The outputs change only on the clock edge that samples `bx_strobe` high. The result of a crossing is visible one cycle after its strobe cycle and holds until the next strobe.
- R3: The reported address is that of the unmasked channel whose hit pulse was sampled in the earliest cycle of the crossing.
- R4: Hit pulses sampled after the first unmasked hit of a crossing do not change the address reported for that crossing.
- R5: If several unmasked channels pulse in the same cycle and that cycle is the earliest of the crossing, the lowest channel index is reported.
- R6: A channel whose `chan_mask` bit is 1 is masked. Its pulses never produce an address and never set `any_hit`. A crossing with only masked pulses reports `addr_valid` = 0 and `any_hit` = 0.
- R7: A crossing without unmasked pulses reports `addr_valid` = 0, `hit_addr` = 0 and `any_hit` = 0.
- R8: A pulse sampled in the strobe cycle belongs to the crossing that is ending. The strobe empties the latch, so no hit carries over into the next crossing.
- R9: `any_hit` equals the OR of all unmasked pulses of the crossing, and it always equals `addr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than the crossing rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bx_strobe | input | 1 | One-cycle pulse in the last sampling cycle of each crossing |
| hit_in | input | 64 | Single-cycle hit pulses, one per channel |
| chan_mask | input | 64 | Per-channel mask, 1 = channel ignored |
| hit_addr | output | 6 | Address of the earliest hit of the last crossing |
| addr_valid | output | 1 | `hit_addr` holds a real channel |
| any_hit | output | 1 | Fast OR of the unmasked channels over the last crossing |

## Verification
A wrong latch state shows at the ports only one cycle after the next strobe. It appears as an address taken from a later pulse, a result carried over from the previous crossing, or a valid flag with no unmasked hit. The bench therefore holds every crossing result for comparison and also compares the outputs on every clock, so a change between strobes is caught within one cycle. Crossings with masked early hits, same-cycle ties, pulses in the strobe cycle and empty crossings expose errors in the latch, the mask and the tie-break rule.

// File: rtl/ea_pkg.sv
package ea_pkg;
  // Default channel count of one front-end bank.
  localparam int unsigned DEF_NUM_CH = 64;
  // Reset synchronizer depth.
  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync #(
  parameter int unsigned STAGES = ea_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ea_lowidx_enc.sv
module ea_lowidx_enc #(
  parameter int unsigned N  = ea_pkg::DEF_NUM_CH,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [AW-1:0] idx
);
  // Scan from the top so the lowest set index is left in idx.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
    found = |req;
  end
endmodule

// File: rtl/ea_first_latch.sv
module ea_first_latch #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cross_end,
  input  logic          found,
  input  logic [AW-1:0] idx,
  output logic          held_vld,
  output logic [AW-1:0] held_addr,
  output logic          res_vld,
  output logic [AW-1:0] res_addr
);
  logic          vld_d;
  logic [AW-1:0] addr_d;
  logic          load_en;

  // Next state: load on the first hit, clear at the end of the crossing.
  always_comb begin
    load_en = cross_end | (found & ~held_vld);
    vld_d   = held_vld;
    addr_d  = held_addr;
    if (cross_end) begin
      vld_d  = 1'b0;
      addr_d = '0;
    end else if (found && !held_vld) begin
      vld_d  = 1'b1;
      addr_d = idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld  <= 1'b0;
      held_addr <= '0;
    end else if (load_en) begin
      held_vld  <= vld_d;
      held_addr <= addr_d;
    end
  end

  // Crossing result: an earlier hit beats the winner of the current cycle.
  always_comb begin
    res_vld  = held_vld | found;
    res_addr = '0;
    if (held_vld)   res_addr = held_addr;
    else if (found) res_addr = idx;
  end
endmodule

// File: rtl/earliest_hit_addr.sv
module earliest_hit_addr #(
  parameter int unsigned NUM_CH = ea_pkg::DEF_NUM_CH,
  localparam int unsigned AW = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bx_strobe,
  input  logic [NUM_CH-1:0] hit_in,
  input  logic [NUM_CH-1:0] chan_mask,
  output logic [AW-1:0]     hit_addr,
  output logic              addr_valid,
  output logic              any_hit
);
  logic              rst_sync_n;
  logic [NUM_CH-1:0] eff_hit;
  logic              cyc_found;
  logic [AW-1:0]     cyc_idx;
  logic              latch_busy;
  logic [AW-1:0]     latch_addr;
  logic              res_vld;
  logic [AW-1:0]     res_addr;
  logic [AW-1:0]     addr_d;
  logic              valid_d;
  logic              any_d;

  ea_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign eff_hit = hit_in & ~chan_mask;

  ea_lowidx_enc #(.N(NUM_CH)) i_enc (
    .req   (eff_hit),
    .found (cyc_found),
    .idx   (cyc_idx)
  );

  ea_first_latch #(.AW(AW)) i_latch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cross_end (bx_strobe),
    .found     (cyc_found),
    .idx       (cyc_idx),
    .held_vld  (latch_busy),
    .held_addr (latch_addr),
    .res_vld   (res_vld),
    .res_addr  (res_addr)
  );

  // Output next state
  always_comb begin
    valid_d = res_vld;
    any_d   = res_vld;
    addr_d  = res_vld ? res_addr : '0;
  end

  // Output registers, enabled once per crossing
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit_addr   <= '0;
      addr_valid <= 1'b0;
      any_hit    <= 1'b0;
    end else if (bx_strobe) begin
      hit_addr   <= addr_d;
      addr_valid <= valid_d;
      any_hit    <= any_d;
    end
  end
endmodule

// File: rtl/ea_chk.sv
module ea_chk #(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bx_strobe,
  input logic [NUM_CH-1:0] eff,
  input logic              held,
  input logic [AW-1:0]     held_addr,
  input logic [AW-1:0]     hit_addr,
  input logic              addr_valid,
  input logic              any_hit
);
  // R7
  no_addr_without_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> hit_addr == '0);

  // R9
  any_matches_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit == addr_valid);

  // R2
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bx_strobe) |-> ($stable(hit_addr) && $stable(addr_valid)));

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_strobe && !held && eff == '0) |=> !addr_valid);

  // R4
  first_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !bx_strobe) |=> (held && $stable(held_addr)));

  // R8
  clear_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bx_strobe |=> !held);

  // R3
  capture_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && eff != '0 && !bx_strobe) |=> held);
endmodule

bind earliest_hit_addr ea_chk #(.NUM_CH(NUM_CH), .AW(AW)) i_ea_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bx_strobe  (bx_strobe),
  .eff        (eff_hit),
  .held       (latch_busy),
  .held_addr  (latch_addr),
  .hit_addr   (hit_addr),
  .addr_valid (addr_valid),
  .any_hit    (any_hit)
);

// File: tb/test_earliest_hit_addr.sv
`timescale 1ns/1ps
module test_earliest_hit_addr;
  localparam int NCH = 64;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bx_strobe;
  logic [NCH-1:0] hit_in;
  logic [NCH-1:0] chan_mask;
  logic [5:0]     hit_addr;
  logic           addr_valid;
  logic           any_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int   first_ch = -1;
  logic exp_vld = 1'b0;
  int   exp_addr = 0;

  always #5 clk = ~clk;

  earliest_hit_addr i_earliest_hit_addr (
    .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .hit_in(hit_in),
    .chan_mask(chan_mask), .hit_addr(hit_addr), .addr_valid(addr_valid),
    .any_hit(any_hit)
  );

  task automatic chk(input string tag, input logic v, input int a);
    checks++;
    if (addr_valid !== v || any_hit !== v || int'(hit_addr) != a) begin
      errors++;
      $display("FAIL %s: got valid=%0b any=%0b addr=%0d, expected valid=%0b any=%0b addr=%0d",
               tag, addr_valid, any_hit, hit_addr, v, v, a);
    end
  endtask

  // One sampling cycle: compare with the model, drive, let the edge pass, update the model.
  task automatic step(input logic s, input logic [NCH-1:0] h, input logic [NCH-1:0] m);
    @(negedge clk);
    chk("R2 per-cycle", exp_vld, exp_addr);
    bx_strobe = s; hit_in = h; chan_mask = m;
    @(posedge clk);
    #1;
    if (first_ch < 0) begin
      for (int i = 0; i < NCH; i++)
        if (first_ch < 0 && h[i] && !m[i]) first_ch = i;
    end
    if (s) begin
      exp_vld  = (first_ch >= 0);
      exp_addr = (first_ch >= 0) ? first_ch : 0;
      first_ch = -1;
    end
  endtask

  task automatic idle(input int n, input logic [NCH-1:0] m);
    for (int k = 0; k < n; k++) step(1'b0, '0, m);
  endtask

  function automatic logic [NCH-1:0] bit1(input int c);
    return {{(NCH-1){1'b0}}, 1'b1} << c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bx_strobe = 1'b0; hit_in = '0; chan_mask = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 in reset", 1'b0, 0);
    end
    rst_n = 1'b1;
    idle(4, '0);
    chk("R1 after release", 1'b0, 0);

    // R7 empty crossing
    idle(5, '0); step(1'b1, '0, '0);
    chk("R7 empty crossing", 1'b0, 0);

    // R3 / R4: first hit 37, later 2 and 60
    idle(1, '0); step(1'b0, bit1(37), '0); idle(1, '0);
    step(1'b0, bit1(2), '0); step(1'b0, bit1(60), '0); step(1'b1, bit1(0), '0);
    chk("R3 earliest channel", 1'b1, 37);
    idle(2, '0);
    chk("R4 later hits ignored, held", 1'b1, 37);

    // R5 tie
    idle(1, '0); step(1'b0, bit1(10) | bit1(50), '0); step(1'b0, bit1(3), '0);
    idle(2, '0); step(1'b1, '0, '0);
    chk("R5 tie lowest index", 1'b1, 10);

    // R6 masked early hit, unmasked later
    idle(1, bit1(5)); step(1'b0, bit1(5), bit1(5)); step(1'b0, bit1(40), bit1(5));
    idle(1, bit1(5)); step(1'b1, '0, bit1(5));
    chk("R6 masked channel loses", 1'b1, 40);

    // R6 only masked hits
    step(1'b0, bit1(7) | bit1(8), bit1(7) | bit1(8)); idle(2, '1);
    step(1'b1, bit1(63), bit1(63));
    chk("R6 masked only crossing", 1'b0, 0);

    // R8 hit in strobe cycle counts; no carry into next crossing
    idle(3, '0); step(1'b1, bit1(63), '0);
    chk("R8 strobe-cycle hit", 1'b1, 63);
    idle(4, '0); step(1'b1, '0, '0);
    chk("R8 cleared next crossing", 1'b0, 0);

    // R8 strobe-cycle hit does not beat an earlier latched hit
    step(1'b0, bit1(20), '0); step(1'b1, bit1(1), '0);
    chk("R8 latched beats strobe-cycle", 1'b1, 20);

    // R9 random crossings against the model
    for (int c = 0; c < 40; c++) begin
      logic [NCH-1:0] m;
      m = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      for (int k = 0; k < 6; k++) begin
        logic [NCH-1:0] h;
        h = '0;
        if ($urandom % 3 == 0) h = bit1(int'($urandom % NCH));
        if ($urandom % 5 == 0) h = h | bit1(int'($urandom % NCH));
        step(k == 5, h, m);
      end
      chk("R9 random crossing", exp_vld, exp_addr);
    end

    idle(2, '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule